// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the device side of a receive path that shares a 16-bit, word-addressed memory with a host. The host builds a ring of descriptors in that memory. Each descriptor names a buffer and gives its size, and the host marks the descriptor as device-owned. For every frame that arrives on the byte stream, the block takes the descriptor at its current ring index and checks that the device owns it. It then copies the frame bytes into the buffer. A frame longer than one buffer continues into the following descriptors. When the frame ends, the block writes back the received length and the status flags, returns ownership to the host, and advances the ring index, which wraps at the end of the ring.

Each descriptor is four consecutive words at `ring_base + 4*index`:

| Word | Contents |
|------|----------|
| +0 | buffer byte address |
| +1 | flag byte in bits 15:8, address-high byte in bits 7:0 |
| +2 | two's complement of the buffer size |
| +3 | received byte count |

The flag byte holds the following bits:

| Bit | Meaning |
|-----|---------|
| 7 | ownership (1 = device owns the descriptor) |
| 6 | error summary |
| 5 | framing error |
| 4 | overflow |
| 3 | CRC error |
| 2 | buffer error |
| 1 | start of frame |
| 0 | end of frame |

When a frame completes, the block raises a one-cycle receive interrupt. When a frame finds its first descriptor still owned by the host, the block drops the frame and raises a one-cycle missed-frame pulse.

Top module: `rx_ring_writer`

## Requirements
- R1: At the start of a frame the block reads word +1 of the descriptor at the current index. It fills that descriptor only when bit 15 (ownership) is 1.
- R2: The buffer byte address comes from word +0 and the buffer size from the negation of word +2; the size must be even and at least 2. Bytes are stored two per word, with the earlier byte in bits 15:8. A trailing odd byte is written with bits 7:0 zero.
- R3: Each descriptor is closed by writing word +1 as {0, flag byte bits 6:0, original address-high byte}, which hands it to the host. The descriptor that ends a frame first gets word +3 written with the frame byte count modulo 4096 (bits 15:12 zero), and that write comes before the flag write.
- R4: A frame that fits in one buffer with no input error leaves a flag byte of exactly 0x03.
- R5: A frame longer than its buffer continues in the next descriptor. The first buffer gets flag 0x02 and no length write. Middle buffers get 0x00. The last buffer gets the end bit 0x01. A frame that exactly fills one buffer uses a single descriptor.
- R6: The CRC, framing and overflow inputs are sampled with the last byte and land in bits 3, 5 and 4 of the final descriptor. Bit 6 is set whenever any error bit (bits 2 to 5) is set.
- R7: If a buffer fills mid-frame and the next descriptor is host-owned, the current descriptor is closed with buffer error, error summary and end set (0x45, plus 0x02 if it is also the first buffer). Its length is the number of bytes stored. The rest of the frame is accepted and discarded.
- R8: A frame whose first descriptor is host-owned is consumed without any memory write. It produces a one-cycle `miss` pulse and leaves the ring index unchanged.
- R9: The ring holds 2^`ring_lg` descriptors, and the index wraps from the last one to 0.
- R10: `rx_int` pulses for exactly one cycle, in the cycle after the flag write that releases the descriptor ending a frame.
- R11: During and right after reset, `in_ready`, `mem_req`, `rx_int` and `miss` are low and the ring index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| ring_base | input | AW | word address of descriptor 0 |
| ring_lg | input | 3 | log2 of the number of descriptors |
| in_valid | input | 1 | a frame byte is offered |
| in_data | input | 8 | frame byte |
| in_last | input | 1 | this byte ends the frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| in_fram_err | input | 1 | framing error, sampled with the last byte |
| in_ovf_err | input | 1 | overflow error, sampled with the last byte |
| in_ready | output | 1 | byte is accepted on this clock |
| mem_req | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | AW | memory word address |
| mem_wdata | output | 16 | write data |
| mem_rdata | input | 16 | read data, valid the cycle after a read |
| rx_int | output | 1 | receive interrupt pulse |
| miss | output | 1 | missed-frame pulse |

## Verification
The bench builds the block with a 12-bit word address and a ring size code of 2. Four descriptors are enough to reach wrap-around and to land a frame on a descriptor the host has not yet returned, within a handful of frames. The 16-byte buffers bring chaining within reach with short frames, along with the exact-fill boundary, a one-byte spill into a wrapped descriptor, and a chain that fails on a host-owned successor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int OWN_BIT = 15;
    localparam logic [1:0] OFS_BUF  = 2'd0;
    localparam logic [1:0] OFS_FLG  = 2'd1;
    localparam logic [1:0] OFS_SIZE = 2'd2;
    localparam logic [1:0] OFS_MLEN = 2'd3;

    typedef enum logic [3:0] {
        S_IDLE, S_RD_FLG, S_CHK_FLG, S_ISS_ADR, S_GET_ADR, S_GET_LEN,
        S_FILL, S_CH_RD, S_CH_CHK, S_W_LEN, S_W_FLG, S_DROP
    } rxr_state_t;

    typedef struct packed {
        logic err;
        logic fram;
        logic ovf;
        logic crc;
        logic buff;
        logic stp;
        logic enp;
    } rxr_flags_t;

    function automatic logic [7:0] make_flags(input logic first, input logic ending,
                                              input logic crc, input logic fram,
                                              input logic ovf, input logic buff);
        rxr_flags_t f;
        f.stp  = first;
        f.enp  = ending;
        f.crc  = ending & crc;
        f.fram = ending & fram;
        f.ovf  = ending & ovf;
        f.buff = ending & buff;
        f.err  = f.crc | f.fram | f.ovf | f.buff;
        return {1'b0, f};
    endfunction

endpackage

// File: rtl/rxr_index.sv
module rxr_index #(
    parameter int IDXW = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      lg,
    input  logic            adv,
    output logic [IDXW-1:0] idx,
    output logic [IDXW-1:0] nxt
);
    logic [IDXW-1:0] mask;

    always_comb begin
        mask = ~({IDXW{1'b1}} << lg);
        nxt  = (idx + 1'b1) & mask;
    end

    always_ff @(posedge clk) begin
        if (rst)      idx <= '0;
        else if (adv) idx <= nxt;
    end
endmodule

// File: rtl/rxr_pack.sv
module rxr_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_clr,
    input  logic        buf_clr,
    input  logic        take,
    input  logic [7:0]  din,
    input  logic        last,
    output logic [15:0] bcnt,
    output logic [11:0] total,
    output logic        wr_now,
    output logic [15:0] wdata
);
    logic [7:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            bcnt  <= '0;
            total <= '0;
        end else begin
            if (frame_clr)  total <= '0;
            else if (take)  total <= total + 12'd1;
            if (buf_clr)    bcnt <= '0;
            else if (take)  bcnt <= bcnt + 16'd1;
            if (take && !bcnt[0]) hold <= din;
        end
    end

    always_comb begin
        wr_now = take & (bcnt[0] | last);
        wdata  = bcnt[0] ? {hold, din} : {din, 8'h00};
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW   = 15,
    parameter int IDXW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ring_base,
    input  logic [2:0]    ring_lg,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_crc_err,
    input  logic          in_fram_err,
    input  logic          in_ovf_err,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          rx_int,
    output logic          miss
);
    rxr_state_t      st;
    logic [IDXW-1:0] idx, nxt;
    logic [AW-1:0]   desc_cur, desc_nxt, buf_word;
    logic [15:0]     bsize, bcnt, wdata;
    logic [11:0]     total;
    logic [7:0]      cur_hi, nxt_hi;
    logic            first, ending, e_crc, e_fram, e_ovf, e_buff;
    logic            take, wr_now, own_seen;

    assign in_ready = (st == S_FILL) || (st == S_DROP);
    assign take     = in_valid & in_ready;
    assign own_seen = mem_rdata[OWN_BIT];
    assign desc_cur = ring_base + AW'({idx, 2'b00});
    assign desc_nxt = ring_base + AW'({nxt, 2'b00});

    rxr_index #(.IDXW(IDXW)) u_index (
        .clk(clk), .rst(rst), .lg(ring_lg), .adv(st == S_W_FLG),
        .idx(idx), .nxt(nxt)
    );

    rxr_pack u_pack (
        .clk(clk), .rst(rst),
        .frame_clr((st == S_CHK_FLG) && own_seen),
        .buf_clr(st == S_GET_LEN),
        .take(take), .din(in_data), .last(in_last),
        .bcnt(bcnt), .total(total), .wr_now(wr_now), .wdata(wdata)
    );

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_RD_FLG: begin
                mem_req  = 1'b1;
                mem_addr = desc_cur + AW'(OFS_FLG);
            end
            S_CHK_FLG: if (own_seen) begin
                mem_req  = 1'b1;
                mem_addr = desc_cur + AW'(OFS_BUF);
            end
            S_ISS_ADR: begin
                mem_req  = 1'b1;
                mem_addr = desc_cur + AW'(OFS_BUF);
            end
            S_GET_ADR: begin
                mem_req  = 1'b1;
                mem_addr = desc_cur + AW'(OFS_SIZE);
            end
            S_FILL: if (wr_now) begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_word + AW'(bcnt[15:1]);
                mem_wdata = wdata;
            end
            S_CH_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_nxt + AW'(OFS_FLG);
            end
            S_W_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_cur + AW'(OFS_MLEN);
                mem_wdata = {4'b0000, total};
            end
            S_W_FLG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_cur + AW'(OFS_FLG);
                mem_wdata = {make_flags(first, ending, e_crc, e_fram, e_ovf, e_buff), cur_hi};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            buf_word <= '0;
            bsize    <= '0;
            cur_hi   <= '0;
            nxt_hi   <= '0;
            first    <= 1'b0;
            ending   <= 1'b0;
            e_crc    <= 1'b0;
            e_fram   <= 1'b0;
            e_ovf    <= 1'b0;
            e_buff   <= 1'b0;
            rx_int   <= 1'b0;
            miss     <= 1'b0;
        end else begin
            rx_int <= 1'b0;
            miss   <= 1'b0;
            case (st)
                S_IDLE:   if (in_valid) st <= S_RD_FLG;
                S_RD_FLG: st <= S_CHK_FLG;
                S_CHK_FLG: begin
                    if (own_seen) begin
                        cur_hi <= mem_rdata[7:0];
                        first  <= 1'b1;
                        ending <= 1'b0;
                        e_crc  <= 1'b0;
                        e_fram <= 1'b0;
                        e_ovf  <= 1'b0;
                        e_buff <= 1'b0;
                        st     <= S_GET_ADR;
                    end else begin
                        miss <= 1'b1;
                        st   <= S_DROP;
                    end
                end
                S_ISS_ADR: st <= S_GET_ADR;
                S_GET_ADR: begin
                    buf_word <= AW'(mem_rdata >> 1);
                    st       <= S_GET_LEN;
                end
                S_GET_LEN: begin
                    bsize <= -mem_rdata;
                    st    <= S_FILL;
                end
                S_FILL: if (take) begin
                    if (in_last) begin
                        e_crc  <= in_crc_err;
                        e_fram <= in_fram_err;
                        e_ovf  <= in_ovf_err;
                        ending <= 1'b1;
                        st     <= S_W_LEN;
                    end else if (bcnt + 16'd1 == bsize) begin
                        st <= S_CH_RD;
                    end
                end
                S_CH_RD: st <= S_CH_CHK;
                S_CH_CHK: begin
                    if (own_seen) begin
                        nxt_hi <= mem_rdata[7:0];
                        st     <= S_W_FLG;
                    end else begin
                        e_buff <= 1'b1;
                        ending <= 1'b1;
                        st     <= S_W_LEN;
                    end
                end
                S_W_LEN: st <= S_W_FLG;
                S_W_FLG: begin
                    first <= 1'b0;
                    if (ending) begin
                        rx_int <= 1'b1;
                        st     <= e_buff ? S_DROP : S_IDLE;
                    end else begin
                        cur_hi <= nxt_hi;
                        st     <= S_ISS_ADR;
                    end
                end
                S_DROP: if (take && in_last) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rxr_sva.sv
module rxr_sva (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic mem_req,
    input logic mem_we,
    input logic rx_int,
    input logic miss
);
    AST_INT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rx_int |=> !rx_int); // R10
    AST_INT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst) rx_int |-> $past(mem_req && mem_we)); // R10
    AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) miss |=> !miss); // R8
    AST_MISS_AFTER_OWN_READ: assert property (@(posedge clk) disable iff (rst) miss |-> $past(mem_req && !mem_we, 2)); // R1
    AST_NO_READ_WHILE_TAKING: assert property (@(posedge clk) disable iff (rst) in_ready |-> !(mem_req && !mem_we)); // R2
    AST_PULSES_APART: assert property (@(posedge clk) disable iff (rst) !(rx_int && miss)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !in_ready && !mem_req && !rx_int && !miss); // R11
endmodule

bind rx_ring_writer rxr_sva u_sva (
    .clk(clk), .rst(rst), .in_ready(in_ready), .mem_req(mem_req),
    .mem_we(mem_we), .rx_int(rx_int), .miss(miss)
);

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
    localparam int AW   = 12;
    localparam int MW   = 1 << AW;
    localparam int D    = 16;
    localparam int RING = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] ring_base = AW'(D);
    logic [2:0] ring_lg = 3'd2;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_crc_err = 1'b0, in_fram_err = 1'b0, in_ovf_err = 1'b0;
    logic in_ready, mem_req, mem_we, rx_int, miss;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    logic hw = 1'b0;
    logic [AW-1:0] ha = '0;
    logic [15:0] hd = '0;
    logic [15:0] mem [0:MW-1] = '{default: 16'h0000};
    logic [15:0] exp_mem [0:MW-1] = '{default: 16'h0000};

    int n_checks = 0, n_fail = 0;
    int n_int = 0, n_miss = 0, e_int = 0, e_miss = 0, m_idx = 0;

    always #10 clk = ~clk;

    rx_ring_writer #(.AW(AW), .IDXW(7)) dut (
        .clk(clk), .rst(rst), .ring_base(ring_base), .ring_lg(ring_lg),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_fram_err(in_fram_err), .in_ovf_err(in_ovf_err),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rx_int(rx_int), .miss(miss)
    );

    always @(posedge clk) begin
        if (hw) mem[ha] <= hd;
        else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) begin
        if (rx_int) n_int++;
        if (miss) n_miss++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [15:0] d);
        @(negedge clk);
        hw = 1'b1; ha = AW'(a); hd = d;
        exp_mem[a] = d;
        @(negedge clk);
        hw = 1'b0;
    endtask

    task automatic arm(input int i);
        host_wr(D + 4*i + 0, 16'h0400 + 16'(i * 16'h40));
        host_wr(D + 4*i + 1, 16'h8000 | 16'(8'h5A + i));
        host_wr(D + 4*i + 2, -16'd16);
        host_wr(D + 4*i + 3, 16'h0000);
    endtask

    task automatic model(input byte unsigned fr[$], input bit crc, input bit fram, input bit ovf);
        int pos, len, i, ba, sz, k, w, nx;
        bit first;
        logic [15:0] t;
        logic [7:0] fl;
        pos = 0; len = fr.size(); i = m_idx; first = 1'b1;
        if (!exp_mem[D + 4*i + 1][15]) begin
            e_miss++;
            return;
        end
        forever begin
            ba = int'(exp_mem[D + 4*i]) >> 1;
            t = -exp_mem[D + 4*i + 2];
            sz = int'(t);
            k = 0;
            while (pos < len && k < sz) begin
                w = ba + k / 2;
                if (k % 2 == 0) exp_mem[w] = {fr[pos], 8'h00};
                else exp_mem[w][7:0] = fr[pos];
                pos++; k++;
            end
            if (pos == len) begin
                fl = {1'b0, crc | fram | ovf, fram, ovf, crc, 1'b0, first, 1'b1};
                exp_mem[D + 4*i + 3] = 16'(pos % 4096);
                exp_mem[D + 4*i + 1] = {fl, exp_mem[D + 4*i + 1][7:0]};
                m_idx = (i + 1) % RING;
                e_int++;
                return;
            end
            nx = (i + 1) % RING;
            if (exp_mem[D + 4*nx + 1][15]) begin
                fl = {6'b0, first, 1'b0};
                exp_mem[D + 4*i + 1] = {fl, exp_mem[D + 4*i + 1][7:0]};
                i = nx;
                first = 1'b0;
            end else begin
                fl = 8'h45 | {6'b0, first, 1'b0};
                exp_mem[D + 4*i + 3] = 16'(pos % 4096);
                exp_mem[D + 4*i + 1] = {fl, exp_mem[D + 4*i + 1][7:0]};
                m_idx = nx;
                e_int++;
                return;
            end
        end
    endtask

    task automatic frame(input int len, input int seed, input bit crc, input bit fram,
                         input bit ovf, input int gap, input string tag);
        byte unsigned fr[$];
        int bad;
        for (int k = 0; k < len; k++) fr.push_back(8'((seed + k) * 7 + 3));
        model(fr, crc, fram, ovf);
        @(negedge clk);
        for (int k = 0; k < len; k++) begin
            in_valid = 1'b1; in_data = fr[k]; in_last = (k == len - 1);
            in_crc_err = crc; in_fram_err = fram; in_ovf_err = ovf;
            forever begin
                if (in_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (20) @(negedge clk);
        bad = -1;
        for (int a = 0; a < MW; a++)
            if (mem[a] !== exp_mem[a] && bad < 0) bad = a;
        if (bad >= 0)
            check(1'b0, {tag, " memory image at word"}, int'(mem[bad]), int'(exp_mem[bad]));
        else
            check(1'b1, tag, 0, 0);
        check(n_int == e_int, {tag, " R10 rx_int count"}, n_int, e_int);
        check(n_miss == e_miss, {tag, " R8 miss count"}, n_miss, e_miss);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0 && mem_req == 1'b0 && rx_int == 1'b0 && miss == 1'b0,
              "R11 reset outputs", {in_ready, mem_req, rx_int, miss}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b0 && mem_req == 1'b0, "R11 idle after reset", {in_ready, mem_req}, 0);
        for (int i = 0; i < RING; i++) arm(i);
        frame(10, 1, 0, 0, 0, 0, "R4 R3 clean frame");
        frame(7, 2, 1, 0, 0, 0, "R2 R6 odd length crc");
        frame(20, 3, 0, 1, 0, 0, "R5 R6 chained framing error");
        frame(5, 4, 0, 0, 0, 0, "R8 R1 host owned miss");
        arm(0); arm(1);
        frame(12, 5, 0, 0, 1, 0, "R9 wrapped overflow");
        frame(30, 6, 0, 0, 0, 0, "R7 chain onto host owned");
        arm(2); arm(3); arm(0); arm(1);
        frame(16, 7, 0, 0, 0, 0, "R5 exact fill");
        frame(17, 8, 0, 0, 0, 2, "R5 R9 spill into wrapped");
        frame(3, 9, 1, 1, 1, 1, "R6 all errors");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule